// File: doc/BRIEF.md
# CSR Access Permission and Read-Modify-Write Unit

This block is the execution front end for control and status register instructions. It receives a 12-bit register number, an operation code, a source operand, the current privilege level, a debug-access flag, the two counter-enable words and the trap-virtual-memory status bit. In the same cycle it decides whether the access is allowed. When it is, the unit returns the old register value, forms the merged write value and pulses a write strobe. When it is not, it raises an illegal-instruction indication and leaves all state alone.

The permission rules come from the register number itself. Bits [9:8] hold the lowest privilege allowed to access the register. Bits [11:10] equal to 3 mark the register as read-only. The user counter window sits at 0xC00 to 0xC1F and the address-translation register at 0x180. Per-address facts that only the register file knows arrive as inputs: whether the register exists (has a read path), whether it accepts writes, and whether an extension predicate allows it. For this block the register storage is modelled as a small array indexed by the low bits of the register number. It starts at zero and takes writes on the clock edge after the request.

Top module: `csr_access_unit`

## Requirements
- R1: An access is illegal when the current privilege (U=0, S=1, M=3) is below the value of address bits [9:8], unless `dbg_access` is 1. The debug flag overrides only this check.
- R2: When address bits [11:10] equal 3, any access with a nonzero write mask is illegal. A read, or a set or clear with operand 0, stays legal.
- R3: `req_op` is encoded as 0 read (mask 0), 1 write (mask all ones, value = operand), 2 set (value all ones, mask = operand) and 3 clear (value 0, mask = operand). A legal write replaces the register with the operand.
- R4: The merged write value is (old & ~mask) | (value & mask). A set therefore ORs the operand into the register, and a clear removes the operand's bits from it.
- R5: When the write mask is zero, no write strobe is issued and the stored value is unchanged.
- R6: An access to a register with `csr_exists`=0 is illegal.
- R7: An access to a register with `csr_has_write`=0 is legal. It returns the old value, raises no strobe and leaves the stored value unchanged.
- R8: For an address in 0xC00 to 0xC1F with counter index (address & 31), an access from a privilege below M is illegal unless that bit of `menable` is set.
- R9: From U, the counter index bit must also be set in `senable`.
- R10: An access to 0x180 from S while `tvm_bit` is 1 is illegal. From M it is legal.
- R11: An illegal access returns `rd_data` 0, raises no strobe and changes no stored value.
- R12: `illegal`, `rd_data`, `wr_strobe` and `wr_data` are valid in the same cycle as the request. Storage resets to zero, and a write is visible to the next access.
- R13: An access with `csr_pred_ok`=0 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the modelled storage |
| rst_n | input | 1 | Active-low reset, clears storage |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | CSR number |
| req_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| req_operand | input | XLEN | Register or zero-extended 5-bit immediate operand |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| dbg_access | input | 1 | Debugger access, bypasses the privilege-level check |
| menable | input | 32 | Machine-level counter enable bits |
| senable | input | 32 | Supervisor-level counter enable bits |
| tvm_bit | input | 1 | Trap-virtual-memory status bit |
| csr_exists | input | 1 | Addressed register has a read path |
| csr_has_write | input | 1 | Addressed register accepts writes |
| csr_pred_ok | input | 1 | Extension predicate allows the register |
| rd_data | output | XLEN | Old value on a legal access, else 0 |
| illegal | output | 1 | Illegal-instruction indication |
| wr_strobe | output | 1 | Write to the register file this cycle |
| wr_data | output | XLEN | Merged write value |

## Verification
The bench targets the edges of the permission decode. It sweeps every level in bits [9:8] against every privilege, with and without debug, so a design that compared the wrong bits or let debug skip the read-only check would misreport legality. Set and clear with a zero operand are driven at read-only addresses. A design that trapped on the operation code instead of on the mask would flag these as illegal, and a design that strobed on a zero mask would rewrite storage. All 32 counter indexes are checked from U, S and M against uneven enable patterns, which exposes a swapped enable word or a wrong index slice. Each refused write is followed by a readback to prove that nothing was stored.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // One flag per reason an access can be refused
    typedef struct packed {
        logic no_read;
        logic pred_fail;
        logic low_priv;
        logic ro_write;
        logic ctr_off;
        logic vm_trap;
    } csr_fault_t;

endpackage

// File: rtl/csr_perm_check.sv
module csr_perm_check
    import csr_acc_pkg::*;
#(
    parameter int          CNT_N    = 32,
    parameter logic [11:0] CTR_BASE = 12'hC00,
    parameter logic [11:0] VM_ADDR  = 12'h180
) (
    input  logic [11:0]      addr,
    input  logic [1:0]       priv,
    input  logic             dbg,
    input  logic             mask_nz,
    input  logic [CNT_N-1:0] men,
    input  logic [CNT_N-1:0] sen,
    input  logic             tvm,
    input  logic             exists,
    input  logic             pred_ok,
    output csr_fault_t       fault,
    output logic             legal
);
    localparam int CIDX_W = $clog2(CNT_N);

    logic              in_ctr_window;
    logic [CIDX_W-1:0] ctr_idx;

    always_comb begin
        in_ctr_window = (addr[11:CIDX_W] == CTR_BASE[11:CIDX_W]);
        ctr_idx       = addr[CIDX_W-1:0];

        fault.no_read   = !exists;
        fault.pred_fail = !pred_ok;
        fault.low_priv  = !dbg && (priv < addr[9:8]);
        fault.ro_write  = (addr[11:10] == 2'b11) && mask_nz;
        fault.ctr_off   = in_ctr_window &&
                          (((priv < PRIV_M) && !men[ctr_idx]) ||
                           ((priv < PRIV_S) && !sen[ctr_idx]));
        fault.vm_trap   = (addr == VM_ADDR) && (priv == PRIV_S) && tvm;

        legal = (fault == '0);
    end
endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge
    import csr_acc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e         op,
    input  logic [XLEN-1:0] operand,
    input  logic [XLEN-1:0] old_val,
    output logic [XLEN-1:0] merged,
    output logic            mask_nz
);
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] value;

    always_comb begin
        unique case (op)
            OP_READ:  begin mask = '0;      value = '0;      end
            OP_WRITE: begin mask = '1;      value = operand; end
            OP_SET:   begin mask = operand; value = '1;      end
            default:  begin mask = operand; value = '0;      end
        endcase
        mask_nz = |mask;
    end

    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        assign merged[b] = mask[b] ? value[b] : old_val[b];
    end
endmodule

// File: rtl/csr_model_store.sv
module csr_model_store #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.mem[idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[idx];

    // Storage only moves on a strobe (R5, R7, R11)
    assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_acc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          IDX_W    = 3,
    parameter logic [11:0] CTR_BASE = 12'hC00,
    parameter logic [11:0] VM_ADDR  = 12'h180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [11:0]     req_addr,
    input  logic [1:0]      req_op,
    input  logic [XLEN-1:0] req_operand,
    input  logic [1:0]      cur_priv,
    input  logic            dbg_access,
    input  logic [31:0]     menable,
    input  logic [31:0]     senable,
    input  logic            tvm_bit,
    input  logic            csr_exists,
    input  logic            csr_has_write,
    input  logic            csr_pred_ok,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal,
    output logic            wr_strobe,
    output logic [XLEN-1:0] wr_data
);
    csr_op_e         op_e;
    logic [XLEN-1:0] old_val;
    logic            mask_nz;
    logic            legal;
    csr_fault_t      fault;

    assign op_e = csr_op_e'(req_op);

    csr_rmw_merge #(.XLEN(XLEN)) u_merge (
        .op      (op_e),
        .operand (req_operand),
        .old_val (old_val),
        .merged  (wr_data),
        .mask_nz (mask_nz)
    );

    csr_perm_check #(.CNT_N(32), .CTR_BASE(CTR_BASE), .VM_ADDR(VM_ADDR)) u_perm (
        .addr    (req_addr),
        .priv    (cur_priv),
        .dbg     (dbg_access),
        .mask_nz (mask_nz),
        .men     (menable),
        .sen     (senable),
        .tvm     (tvm_bit),
        .exists  (csr_exists),
        .pred_ok (csr_pred_ok),
        .fault   (fault),
        .legal   (legal)
    );

    always_comb begin
        illegal   = req_valid && !legal;
        wr_strobe = req_valid && legal && mask_nz && csr_has_write;
        rd_data   = (req_valid && legal) ? old_val : '0;
    end

    csr_model_store #(.XLEN(XLEN), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_strobe),
        .idx   (req_addr[IDX_W-1:0]),
        .wdata (wr_data),
        .rdata (old_val)
    );

    assert_low_priv_traps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dbg_access && (cur_priv < req_addr[9:8])) |-> illegal);

    assert_ro_write_traps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[11:10] == 2'b11) &&
         ((req_op == 2'd1) || ((req_op != 2'd0) && (req_operand != '0)))) |-> illegal);

    assert_set_merges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && (req_op == 2'd2)) |-> (wr_data == (rd_data | req_operand)));

    assert_missing_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !csr_exists) |-> illegal);

    assert_vm_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr == VM_ADDR) && (cur_priv == PRIV_S) && tvm_bit) |-> illegal);

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_strobe && (rd_data == '0)));

    assert_pred_fail_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !csr_pred_ok) |-> illegal);
endmodule

// File: tb/csr_access_unit_tb.sv
module csr_access_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_operand = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic        dbg_access = 1'b0;
    logic [31:0] menable = '0;
    logic [31:0] senable = '0;
    logic        tvm_bit = 1'b0;
    logic        csr_exists = 1'b1;
    logic        csr_has_write = 1'b1;
    logic        csr_pred_ok = 1'b1;
    logic [31:0] rd_data;
    logic        illegal;
    logic        wr_strobe;
    logic [31:0] wr_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_mem [8];

    always #4 clk = ~clk;

    csr_access_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_operand(req_operand), .cur_priv(cur_priv),
        .dbg_access(dbg_access), .menable(menable), .senable(senable),
        .tvm_bit(tvm_bit), .csr_exists(csr_exists), .csr_has_write(csr_has_write),
        .csr_pred_ok(csr_pred_ok), .rd_data(rd_data), .illegal(illegal),
        .wr_strobe(wr_strobe), .wr_data(wr_data)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic access(input logic [11:0] a, input logic [1:0] op,
                          input logic [31:0] opd, input logic [1:0] pv,
                          input logic dbg, input logic ex, input logic wr,
                          input logic pr, input logic [31:0] me,
                          input logic [31:0] se, input logic tv, input string tag);
        logic [31:0] mask, val, old, merged;
        logic        ok, ctr_ok, exp_we;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_op = op; req_operand = opd;
        cur_priv = pv; dbg_access = dbg; csr_exists = ex; csr_has_write = wr;
        csr_pred_ok = pr; menable = me; senable = se; tvm_bit = tv;
        #1;
        case (op)
            2'd0: begin mask = 32'h0;  val = 32'h0; end
            2'd1: begin mask = '1;     val = opd;   end
            2'd2: begin mask = opd;    val = '1;    end
            default: begin mask = opd; val = 32'h0; end
        endcase
        old    = exp_mem[a[2:0]];
        merged = (old & ~mask) | (val & mask);
        ctr_ok = 1'b1;
        if (a[11:5] == 7'h60) begin
            if (pv != 2'd3 && !me[a[4:0]]) ctr_ok = 1'b0;
            if (pv == 2'd0 && !se[a[4:0]]) ctr_ok = 1'b0;
        end
        ok = ex && pr && (dbg || pv >= a[9:8]) &&
             !(a[11:10] == 2'b11 && mask != 0) && ctr_ok &&
             !(a == 12'h180 && pv == 2'd1 && tv);
        exp_we = ok && (mask != 0) && wr;
        check(tag, "illegal", {31'b0, illegal}, {31'b0, !ok});
        check(tag, "rd_data", rd_data, ok ? old : 32'h0);
        check(tag, "wr_strobe", {31'b0, wr_strobe}, {31'b0, exp_we});
        if (exp_we) begin
            check(tag, "wr_data", wr_data, merged);
            exp_mem[a[2:0]] = merged;
        end
    endtask

    // Plain M-mode access with all register-file flags true
    task automatic macc(input logic [11:0] a, input logic [1:0] op,
                        input logic [31:0] opd, input string tag);
        access(a, op, opd, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, '1, '1, 1'b0, tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pat;
        for (int i = 0; i < 8; i++) exp_mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset contents and same-cycle results
        for (int i = 0; i < 8; i++) macc(12'h340 + 12'(i), 2'd0, 32'h0, "R12");

        // R3: full writes, then readback through the next access (R12)
        for (int i = 0; i < 8; i++) begin
            pat = 32'h1357_9BDF * (i + 1) ^ 32'hA5A5_0F0F;
            macc(12'h340 + 12'(i), 2'd1, pat, "R3");
        end
        for (int i = 0; i < 8; i++) macc(12'h340 + 12'(i), 2'd0, 32'h0, "R12");

        // R4: set and clear with varied operands
        for (int i = 0; i < 16; i++) begin
            pat = (32'h0F0F_1234 << (i % 7)) ^ (32'(i) * 32'h0101_0101);
            macc(12'h340 + 12'(i % 8), (i % 2 == 0) ? 2'd2 : 2'd3, pat, "R4");
        end

        // R5: zero-mask set and clear, and immediate-width operands
        for (int i = 0; i < 8; i++) begin
            macc(12'h340 + 12'(i), 2'd2, 32'h0, "R5");
            macc(12'h340 + 12'(i), 2'd3, 32'h0, "R5");
            macc(12'h340 + 12'(i), 2'd0, 32'h0, "R5");
            macc(12'h340 + 12'(i), 2'd2, 32'(i * 3 + 1) & 32'h1F, "R4");
        end

        // R1: every level against every privilege, with and without debug
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 4; p++)
                for (int d = 0; d < 2; d++)
                    access(12'h040 | 12'(l << 8) | 12'(p), 2'd0, 32'h0, 2'(p),
                           1'(d), 1'b1, 1'b1, 1'b1, '1, '1, 1'b0, "R1");

        // R1 debug does not lift the read-only rule (R2)
        access(12'hF45, 2'd1, 32'h55, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, '1, '1, 1'b0, "R2");

        // R2: read-only addresses under each op, zero and nonzero operand
        for (int op = 0; op < 4; op++) begin
            macc(12'hF42, 2'(op), 32'h0, "R2");
            macc(12'hC43, 2'(op), 32'h0000_0011, "R2");
        end

        // R6, R7, R13: register-file flag combinations
        for (int f = 0; f < 8; f++) begin
            access(12'h346, 2'd1, 32'hC0DE_0000 | 32'(f), 2'd3, 1'b0,
                   1'(f), 1'(f >> 1), 1'(f >> 2), '1, '1, 1'b0,
                   (f[0] == 1'b0) ? "R6" : (f[2] == 1'b0) ? "R13" : "R7");
            macc(12'h346, 2'd0, 32'h0, "R7");
        end

        // R8, R9: counter window, every index, each privilege
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 32; i++)
                access(12'hC00 + 12'(i), 2'd0, 32'h0, (p == 2) ? 2'd3 : 2'(p),
                       1'b0, 1'b1, 1'b1, 1'b1, 32'hB5C3_96E1, 32'h6F0A_3D95,
                       1'b0, (p == 0) ? "R9" : "R8");

        // R10: translation register against trap-VM bit
        for (int t = 0; t < 2; t++) begin
            access(12'h180, 2'd1, 32'h8000_1234 + 32'(t), 2'd1, 1'b0, 1'b1, 1'b1,
                   1'b1, '1, '1, 1'(t), "R10");
            access(12'h180, 2'd0, 32'h0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, '1, '1,
                   1'(t), "R10");
        end

        // R11: refused writes leave storage untouched
        for (int i = 0; i < 8; i++) begin
            access(12'h300 + 12'(i), 2'd1, 32'hDEAD_BEEF, 2'd1, 1'b0, 1'b1, 1'b1,
                   1'b1, '1, '1, 1'b0, "R11");
            macc(12'h300 + 12'(i), 2'd0, 32'h0, "R11");
        end

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R11", "idle strobe", {31'b0, wr_strobe}, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule